// File: doc/BRIEF.md
# Stream Link FIFO Interrupt Controller

This block turns the FIFO status flags of up to eight receive links and up to eight transmit links into two interrupt lines, one for the receive side and one for the transmit side. Each link has an enable bit and a mode bit in a single 32-bit configuration word. The mode picks which FIFO condition the link reports. The FIFOs and their stream handshakes sit outside the block. Their status comes in as level flags, and bus activity comes in as one-cycle strobes.

An interrupt is raised by a change, not by a level. Each link's qualified condition is registered every cycle. A rise on any enabled link sets the pending flag of its side. The flag then stays set until software acknowledges it or the unit is turned off. A receive interrupt is acknowledged by a data read or a configuration write. A transmit interrupt is acknowledged by a data write or a configuration write. Because only edges count, a FIFO that stays in the same state does not raise the interrupt again after it has been acknowledged.

Top module: `stream_irq_ctrl`

## Requirements
- R1: The configuration word is read back unchanged, masked to the implemented links. Bits 31:24 are the receive enables, 23:16 the receive modes, 15:8 the transmit enables and 7:0 the transmit modes, with bit i of each field belonging to link i. After reset the word reads 0 and both interrupts are low.
- R2: For an enabled receive link in mode 1, `rx_not_empty` going from 0 to 1 makes `irq_rx` high after the next rising clock edge.
- R3: For an enabled receive link in mode 0, `rx_at_half` (FIFO at least half full) going from 0 to 1 sets `irq_rx`. `rx_not_empty` alone does not set it.
- R4: For an enabled transmit link in mode 1, `tx_not_full` going from 0 to 1 sets `irq_tx`.
- R5: For an enabled transmit link in mode 0, `tx_at_half` going from 1 to 0 (FIFO drops below half full) sets `irq_tx`.
- R6: A condition that stays true after an acknowledge does not raise the interrupt again.
- R7: A link whose enable bit is clear cannot set either interrupt.
- R8: Each interrupt is the OR over its enabled links: a rise on any one of them sets it.
- R9: A pending `irq_rx` is cleared one cycle after `data_rd` or `cfg_wr`. `data_wr` leaves it set.
- R10: A pending `irq_tx` is cleared one cycle after `data_wr` or `cfg_wr`. `data_rd` leaves it set.
- R11: While `unit_en` is low, both interrupts are low and no edge is recorded. Setting `unit_en` while a condition is true counts as a rise.
- R12: If an acknowledge and a new rise fall in the same cycle, the interrupt stays pending.
- R13: With a FIFO depth parameter of 1, that side's mode bits read as all ones for the implemented links and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| unit_en | input | 1 | Global enable of the unit |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Current configuration word |
| data_rd | input | 1 | Strobe: a link data register was read |
| data_wr | input | 1 | Strobe: a link data register was written |
| rx_not_empty | input | NUM_RX | Receive FIFO holds at least one word, per link |
| rx_at_half | input | NUM_RX | Receive FIFO is at least half full, per link |
| tx_not_full | input | NUM_TX | Transmit FIFO has free space, per link |
| tx_at_half | input | NUM_TX | Transmit FIFO is at least half full, per link |
| irq_rx | output | 1 | Receive-side interrupt pending |
| irq_tx | output | 1 | Transmit-side interrupt pending |

## Verification
The assertions assume that the strobes and flags are synchronous, single-driver inputs that are stable around the clock edge. They also assume that reset is held for at least one edge before any property is judged. The properties do not assume that the FIFO flags are consistent with each other (half full without not-empty, for example). The bench still keeps each flag pattern physically plausible, and it clears all flags before it enables a link, so that every interrupt it expects comes from a deliberate edge. The bench drives every input on the falling edge and samples one full cycle later, so each strobe lasts exactly one clock.

// File: rtl/stream_irq_pkg.sv
package stream_irq_pkg;

  localparam int LINK_FIELD = 8;

  typedef struct packed {
    logic [LINK_FIELD-1:0] rx_en;
    logic [LINK_FIELD-1:0] rx_mode;
    logic [LINK_FIELD-1:0] tx_en;
    logic [LINK_FIELD-1:0] tx_mode;
  } irq_cfg_t;

  // Receive condition: mode 1 watches "not empty", mode 0 watches "at least half".
  function automatic logic rx_event_level(input logic mode, input logic not_empty,
                                          input logic at_half);
    return mode ? not_empty : at_half;
  endfunction

  // Transmit condition: mode 1 watches "not full", mode 0 watches "below half".
  function automatic logic tx_event_level(input logic mode, input logic not_full,
                                          input logic at_half);
    return mode ? not_full : ~at_half;
  endfunction

  function automatic logic [LINK_FIELD-1:0] link_mask(input int count);
    logic [LINK_FIELD-1:0] m;
    for (int b = 0; b < LINK_FIELD; b++) m[b] = (b < count);
    return m;
  endfunction

endpackage

// File: rtl/irq_cfg_reg.sv
module irq_cfg_reg
  import stream_irq_pkg::*;
#(
  parameter int NUM_RX   = 8,
  parameter int NUM_TX   = 8,
  parameter int RX_DEPTH = 4,
  parameter int TX_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [31:0] wdata,
  output irq_cfg_t    cfg
);

  localparam logic [LINK_FIELD-1:0] RX_MASK = link_mask(NUM_RX);
  localparam logic [LINK_FIELD-1:0] TX_MASK = link_mask(NUM_TX);

  irq_cfg_t wr_view;
  logic [LINK_FIELD-1:0] rx_en_q, tx_en_q, rx_mode_w, tx_mode_w;

  assign wr_view = irq_cfg_t'(wdata);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_en_q <= '0;
      tx_en_q <= '0;
    end else if (wr) begin
      rx_en_q <= wr_view.rx_en & RX_MASK;
      tx_en_q <= wr_view.tx_en & TX_MASK;
    end
  end

  generate
    if (RX_DEPTH == 1) begin : g_rx_mode_fixed
      assign rx_mode_w = RX_MASK;
    end else begin : g_rx_mode_reg
      logic [LINK_FIELD-1:0] rx_mode_q;
      always_ff @(posedge clk) begin
        if (!rst_n)  rx_mode_q <= '0;
        else if (wr) rx_mode_q <= wr_view.rx_mode & RX_MASK;
      end
      assign rx_mode_w = rx_mode_q;
    end

    if (TX_DEPTH == 1) begin : g_tx_mode_fixed
      assign tx_mode_w = TX_MASK;
    end else begin : g_tx_mode_reg
      logic [LINK_FIELD-1:0] tx_mode_q;
      always_ff @(posedge clk) begin
        if (!rst_n)  tx_mode_q <= '0;
        else if (wr) tx_mode_q <= wr_view.tx_mode & TX_MASK;
      end
      assign tx_mode_w = tx_mode_q;
    end
  endgenerate

  assign cfg.rx_en   = rx_en_q;
  assign cfg.rx_mode = rx_mode_w;
  assign cfg.tx_en   = tx_en_q;
  assign cfg.tx_mode = tx_mode_w;

endmodule

// File: rtl/link_edge_det.sv
module link_edge_det #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         unit_en,
  input  logic [N-1:0] level,
  output logic [N-1:0] rise
);

  generate
    for (genvar i = 0; i < N; i++) begin : g_link
      logic prev_q;
      always_ff @(posedge clk) begin
        if (!rst_n)        prev_q <= 1'b0;
        else if (!unit_en) prev_q <= 1'b0;
        else               prev_q <= level[i];
      end
      assign rise[i] = level[i] & ~prev_q;
    end
  endgenerate

endmodule

// File: rtl/irq_pending.sv
module irq_pending (
  input  logic clk,
  input  logic rst_n,
  input  logic unit_en,
  input  logic set_evt,
  input  logic ack,
  output logic pend
);

  always_ff @(posedge clk) begin
    if (!rst_n)        pend <= 1'b0;
    else if (!unit_en) pend <= 1'b0;
    else if (set_evt)  pend <= 1'b1;
    else if (ack)      pend <= 1'b0;
  end

endmodule

// File: rtl/stream_irq_ctrl.sv
module stream_irq_ctrl
  import stream_irq_pkg::*;
#(
  parameter int NUM_RX   = 8,
  parameter int NUM_TX   = 8,
  parameter int RX_DEPTH = 4,
  parameter int TX_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              unit_en,
  input  logic              cfg_wr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              data_rd,
  input  logic              data_wr,
  input  logic [NUM_RX-1:0] rx_not_empty,
  input  logic [NUM_RX-1:0] rx_at_half,
  input  logic [NUM_TX-1:0] tx_not_full,
  input  logic [NUM_TX-1:0] tx_at_half,
  output logic              irq_rx,
  output logic              irq_tx
);

  irq_cfg_t cfg;
  logic [NUM_RX-1:0] rx_level, rx_rise;
  logic [NUM_TX-1:0] tx_level, tx_rise;
  logic rx_rise_any, tx_rise_any, rx_ack, tx_ack;

  irq_cfg_reg #(
    .NUM_RX(NUM_RX), .NUM_TX(NUM_TX), .RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wdata(cfg_wdata), .cfg(cfg)
  );

  generate
    for (genvar i = 0; i < NUM_RX; i++) begin : g_rx
      assign rx_level[i] = unit_en & cfg.rx_en[i] &
                           rx_event_level(cfg.rx_mode[i], rx_not_empty[i], rx_at_half[i]);
    end
    for (genvar j = 0; j < NUM_TX; j++) begin : g_tx
      assign tx_level[j] = unit_en & cfg.tx_en[j] &
                           tx_event_level(cfg.tx_mode[j], tx_not_full[j], tx_at_half[j]);
    end
  endgenerate

  link_edge_det #(.N(NUM_RX)) u_rx_edge (
    .clk(clk), .rst_n(rst_n), .unit_en(unit_en), .level(rx_level), .rise(rx_rise)
  );
  link_edge_det #(.N(NUM_TX)) u_tx_edge (
    .clk(clk), .rst_n(rst_n), .unit_en(unit_en), .level(tx_level), .rise(tx_rise)
  );

  assign rx_rise_any = |rx_rise;
  assign tx_rise_any = |tx_rise;
  assign rx_ack      = data_rd | cfg_wr;
  assign tx_ack      = data_wr | cfg_wr;

  irq_pending u_rx_pend (
    .clk(clk), .rst_n(rst_n), .unit_en(unit_en),
    .set_evt(rx_rise_any), .ack(rx_ack), .pend(irq_rx)
  );
  irq_pending u_tx_pend (
    .clk(clk), .rst_n(rst_n), .unit_en(unit_en),
    .set_evt(tx_rise_any), .ack(tx_ack), .pend(irq_tx)
  );

  assign cfg_rdata = 32'(cfg);

endmodule

// File: rtl/stream_irq_ctrl_chk.sv
module stream_irq_ctrl_chk #(
  parameter int NUM_RX = 8,
  parameter int NUM_TX = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        unit_en,
  input logic        cfg_wr,
  input logic [31:0] cfg_wdata,
  input logic [31:0] cfg_rdata,
  input logic        irq_rx,
  input logic        irq_tx,
  input logic        rx_rise_any,
  input logic        tx_rise_any,
  input logic        rx_ack,
  input logic        tx_ack
);

  logic [7:0] rx_keep;
  always_comb begin
    rx_keep = '0;
    for (int b = 0; b < NUM_RX; b++) rx_keep[b] = 1'b1;
  end

  // R1: the receive enable field follows the last write
  p_cfg_readback_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> cfg_rdata[31:24] == ($past(cfg_wdata[31:24]) & rx_keep));

  // R2: a receive rise makes the interrupt pending
  p_rx_rise_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_en && rx_rise_any) |=> irq_rx);

  // R4: a transmit rise makes the interrupt pending
  p_tx_rise_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_en && tx_rise_any) |=> irq_tx);

  // R6: without a rise the receive interrupt cannot appear
  p_rx_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_rx && !rx_rise_any) |=> !irq_rx);

  p_tx_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_tx && !tx_rise_any) |=> !irq_tx);

  // R9: acknowledge without a competing rise clears the receive side
  p_rx_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ack && !rx_rise_any) |=> !irq_rx);

  // R10: acknowledge without a competing rise clears the transmit side
  p_tx_ack_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ack && !tx_rise_any) |=> !irq_tx);

  // R11: a disabled unit keeps both lines low
  p_off_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !unit_en |=> (!irq_rx && !irq_tx));

  // R12: pending stays while enabled and not acknowledged
  p_rx_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_rx && unit_en && !rx_ack) |=> irq_rx);

endmodule

bind stream_irq_ctrl stream_irq_ctrl_chk #(.NUM_RX(NUM_RX), .NUM_TX(NUM_TX)) u_chk (
  .clk(clk), .rst_n(rst_n), .unit_en(unit_en), .cfg_wr(cfg_wr),
  .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq_rx(irq_rx), .irq_tx(irq_tx),
  .rx_rise_any(rx_rise_any), .tx_rise_any(tx_rise_any),
  .rx_ack(rx_ack), .tx_ack(tx_ack)
);

// File: tb/stream_irq_ctrl_test.sv
module stream_irq_ctrl_test;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, unit_en, cfg_wr, data_rd, data_wr;
  logic [31:0] cfg_wdata, cfg_rdata, cfg_rdata_d1;
  logic [7:0] rx_ne, rx_half, tx_nf, tx_half;
  logic irq_rx, irq_tx, irq_rx_d1, irq_tx_d1;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stream_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .unit_en(unit_en), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .data_rd(data_rd), .data_wr(data_wr),
    .rx_not_empty(rx_ne), .rx_at_half(rx_half), .tx_not_full(tx_nf), .tx_at_half(tx_half),
    .irq_rx(irq_rx), .irq_tx(irq_tx)
  );

  stream_irq_ctrl #(.RX_DEPTH(1), .TX_DEPTH(1)) uut_d1 (
    .clk(clk), .rst_n(rst_n), .unit_en(unit_en), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata_d1), .data_rd(data_rd), .data_wr(data_wr),
    .rx_not_empty(8'h00), .rx_at_half(8'h00), .tx_not_full(8'h00), .tx_at_half(8'h00),
    .irq_rx(irq_rx_d1), .irq_tx(irq_tx_d1)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic cfg_write(input logic [31:0] w);
    cfg_wdata = w; cfg_wr = 1'b1;
    tick();
    cfg_wr = 1'b0;
  endtask

  task automatic pulse_rd();
    data_rd = 1'b1; tick(); data_rd = 1'b0;
  endtask

  task automatic pulse_wr();
    data_wr = 1'b1; tick(); data_wr = 1'b0;
  endtask

  task automatic quiet_flags();
    rx_ne = '0; rx_half = '0; tx_nf = '0; tx_half = '0;
    tick();
  endtask

  task automatic t_reset();
    check("R1 reset cfg", cfg_rdata, 32'h0);
    check("R1 reset irq_rx", 32'(irq_rx), 32'h0);
    check("R1 reset irq_tx", 32'(irq_tx), 32'h0);
  endtask

  task automatic t_cfg_readback();
    cfg_write(32'hA53C0F81);
    check("R1 readback", cfg_rdata, 32'hA53C0F81);
    check("R13 depth1 modes fixed", cfg_rdata_d1, 32'hA5FF0FFF);
    cfg_write(32'h0);
    check("R13 depth1 modes ignore write", cfg_rdata_d1 & 32'h00FF00FF, 32'h00FF00FF);
  endtask

  task automatic t_rx_not_empty();
    quiet_flags();
    cfg_write(32'h01010000);
    check("R2 idle", 32'(irq_rx), 32'h0);
    rx_ne[0] = 1'b1; tick();
    check("R2 rise sets irq_rx", 32'(irq_rx), 32'h1);
    check("R2 irq_tx unaffected", 32'(irq_tx), 32'h0);
    pulse_wr();
    check("R9 data_wr keeps irq_rx", 32'(irq_rx), 32'h1);
    pulse_rd();
    check("R9 data_rd clears irq_rx", 32'(irq_rx), 32'h0);
    tick(); tick();
    check("R6 held level no retrigger", 32'(irq_rx), 32'h0);
  endtask

  task automatic t_rx_half();
    quiet_flags();
    cfg_write(32'h04000000);
    rx_ne[2] = 1'b1; tick();
    check("R3 not-empty ignored in mode 0", 32'(irq_rx), 32'h0);
    rx_half[2] = 1'b1; tick();
    check("R3 half rise sets irq_rx", 32'(irq_rx), 32'h1);
    cfg_write(32'h04000000);
    check("R9 cfg_wr clears irq_rx", 32'(irq_rx), 32'h0);
  endtask

  task automatic t_tx_not_full();
    quiet_flags();
    cfg_write(32'h00000808);
    tx_nf[3] = 1'b1; tick();
    check("R4 not-full rise sets irq_tx", 32'(irq_tx), 32'h1);
    check("R4 irq_rx unaffected", 32'(irq_rx), 32'h0);
    pulse_rd();
    check("R10 data_rd keeps irq_tx", 32'(irq_tx), 32'h1);
    pulse_wr();
    check("R10 data_wr clears irq_tx", 32'(irq_tx), 32'h0);
  endtask

  task automatic t_tx_below_half();
    quiet_flags();
    tx_half[5] = 1'b1; tick();
    cfg_write(32'h00002000);
    tick();
    check("R5 above half idle", 32'(irq_tx), 32'h0);
    tx_half[5] = 1'b0; tick();
    check("R5 drop below half sets irq_tx", 32'(irq_tx), 32'h1);
    cfg_write(32'h00002000);
    check("R10 cfg_wr clears irq_tx", 32'(irq_tx), 32'h0);
  endtask

  task automatic t_disabled_and_or();
    quiet_flags();
    cfg_write(32'h01FF0000);
    rx_ne[4] = 1'b1; tick();
    check("R7 disabled link ignored", 32'(irq_rx), 32'h0);
    quiet_flags();
    cfg_write(32'h90900000);
    rx_ne[7] = 1'b1; tick();
    check("R8 link 7 sets irq_rx", 32'(irq_rx), 32'h1);
    pulse_rd();
    rx_ne[4] = 1'b1; tick();
    check("R8 link 4 sets irq_rx", 32'(irq_rx), 32'h1);
    pulse_rd();
  endtask

  task automatic t_ack_race();
    quiet_flags();
    cfg_write(32'h03030000);
    rx_ne[0] = 1'b1; tick();
    check("R12 first rise", 32'(irq_rx), 32'h1);
    data_rd = 1'b1; rx_ne[1] = 1'b1; tick(); data_rd = 1'b0;
    check("R12 rise beats ack", 32'(irq_rx), 32'h1);
    pulse_rd();
    check("R12 later ack clears", 32'(irq_rx), 32'h0);
  endtask

  task automatic t_unit_off();
    quiet_flags();
    cfg_write(32'h01010101);
    rx_ne[0] = 1'b1; tx_nf[0] = 1'b1; tick();
    check("R11 both pending", {30'h0, irq_rx, irq_tx}, 32'h3);
    unit_en = 1'b0; tick();
    check("R11 disable clears", {30'h0, irq_rx, irq_tx}, 32'h0);
    rx_ne[0] = 1'b0; tick(); rx_ne[0] = 1'b1; tick();
    check("R11 edges blocked while off", {30'h0, irq_rx, irq_tx}, 32'h0);
    unit_en = 1'b1; tick();
    check("R11 enable with condition true", {30'h0, irq_rx, irq_tx}, 32'h3);
  endtask

  initial begin
    rst_n = 1'b0; unit_en = 1'b1; cfg_wr = 1'b0; data_rd = 1'b0; data_wr = 1'b0;
    cfg_wdata = '0; rx_ne = '0; rx_half = '0; tx_nf = '0; tx_half = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_cfg_readback();
    t_rx_not_empty();
    t_rx_half();
    t_tx_not_full();
    t_tx_below_half();
    t_disabled_and_or();
    t_ack_race();
    t_unit_off();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule